// File: doc/BRIEF.md
# Two-Bank Interleaved DRAM Precharge Scheduler

This block sits between a 32-bit processor-style bus and a memory made of two DRAM banks. One bank holds the even doubleword addresses and the other holds the odd ones. The bank is chosen from address bit 2, the lowest bit above the byte offset inside a doubleword. For each accepted request the block pulses a start strobe to that bank, counts the configured access length, and then pulses ready back to the requester.

After each access a bank needs an idle recovery interval before it can be used again. Each bank has its own down-counter for this interval. A request to a bank that is still recovering is held inside the block and launched once that bank's counter reaches zero. A request to the other bank launches at once. A run of sequential doubleword accesses therefore alternates banks and runs without added waits, while a repeated hit on one bank stalls.

Access length and recovery length are parameters in clock cycles. Address multiplexing, refresh, strobe waveforms and the data path are outside this block.

Top module: `dram_ilv_sched`

## Requirements
- R1: Bank select is address bit 2. Bit 2 equal to 0 launches on start[0], and bit 2 equal to 1 launches on start[1]. No other address bit affects the choice.
- R2: After reset both banks count as recovered. The first access to either bank asserts its start bit in the cycle right after the cycle in which req was sampled high.
- R3: During reset and after it, start and ready are low. For each access, ready is high for exactly one cycle. That cycle is the ACC_CYC-th cycle of the access, counting the start cycle as the first.
- R4: When an access ends, its bank's recovery counter loads PRE_CYC. A request to the same bank, issued in the first cycle after ready, starts exactly PRE_CYC cycles later than an unstalled request would.
- R5: A request to the other bank does not wait, provided that bank's own counter has run out. With PRE_CYC <= ACC_CYC+1, alternating even/odd doubleword accesses issued back to back never stall.
- R6: A stalled request is held, not dropped. It later launches exactly once, on the bank it addressed. start_we equals the wr value sampled with the request.
- R7: req is ignored while an access is pending, that is from the cycle after acceptance through the ready cycle. Such a pulse produces no start and no ready.
- R8: At most one start bit is high in any cycle, and each access produces a single one-cycle start pulse.
- R9: Idle cycles after ready count toward recovery. A same-bank request issued g cycles late waits max(PRE_CYC-g, 0) extra cycles.
- R10: Asserting reset while a request is stalled discards it. No start follows, and the next access to that bank starts without waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle request strobe |
| addr | input | ADDR_W | Byte address of the request; bit 2 picks the bank |
| wr | input | 1 | 1 for a write, 0 for a read, sampled with req |
| start | output | 2 | Per-bank one-cycle access start strobe |
| start_we | output | 1 | Write flag of the access being started |
| ready | output | 1 | One-cycle completion pulse to the requester |

## Verification
Start latency is measured per request. A recovery counter that fails to load, or a bank select taken from the wrong bit, shows up as a same-bank repeat that starts too early or an alternating access that starts late. The error is visible in the very first start pulse after the faulty access. A lost or duplicated held request shows as a missing start, or as an extra start or ready, within ACC_CYC+PRE_CYC cycles of the request. A wrong access counter shifts ready away from its fixed offset of ACC_CYC-1 cycles after start.

// File: rtl/dram_ilv_sched.sv
`timescale 1ns/1ps
module dram_ilv_sched #(
  parameter int ADDR_W   = 32,
  parameter int ACC_CYC  = 3,
  parameter int PRE_CYC  = 4,
  parameter int BANK_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic [1:0]        start,
  output logic              start_we,
  output logic              ready
);
  localparam int AW = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
  localparam int PW = $clog2(PRE_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACC} st_t;

  st_t            st;
  logic           bank_q, we_q;
  logic [AW-1:0]  acc_q;
  logic [PW-1:0]  pre_q [0:1];

  wire  sel_bank = (st == S_IDLE) ? addr[BANK_BIT] : bank_q;
  wire  sel_we   = (st == S_IDLE) ? wr : we_q;
  wire  sel_free = (pre_q[sel_bank] == '0);
  wire  launch   = ((st == S_IDLE && req) || st == S_WAIT) && sel_free;
  wire  finish   = (st == S_ACC) && (acc_q == '0);

  assign ready = finish;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bank_q   <= 1'b0;
      we_q     <= 1'b0;
      acc_q    <= '0;
      start    <= 2'b00;
      start_we <= 1'b0;
    end else begin
      start <= launch ? (2'b01 << sel_bank) : 2'b00;
      if (launch) start_we <= sel_we;
      case (st)
        S_IDLE: if (req) begin
          bank_q <= addr[BANK_BIT];
          we_q   <= wr;
          st     <= sel_free ? S_ACC : S_WAIT;
          acc_q  <= AW'(ACC_CYC - 1);
        end
        S_WAIT: if (sel_free) begin
          st    <= S_ACC;
          acc_q <= AW'(ACC_CYC - 1);
        end
        S_ACC: if (finish) st <= S_IDLE;
               else        acc_q <= acc_q - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (!rst_n)                          pre_q[b] <= '0;
      else if (finish && bank_q == 1'(b))  pre_q[b] <= PW'(PRE_CYC);
      else if (pre_q[b] != '0)             pre_q[b] <= pre_q[b] - 1'b1;
    end
  end

  p_start_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start));

  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  p_ready_loads_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> pre_q[bank_q] == PW'(PRE_CYC));

  p_wait_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && pre_q[bank_q] > 1) |=> start == 2'b00);

  p_busy_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACC) |=> start == 2'b00);
endmodule

// File: tb/sim_dram_ilv_sched.sv
`timescale 1ns/1ps
module sim_dram_ilv_sched;
  localparam int ACC = 3;
  localparam int PRE = 4;
  localparam int NV  = 14;

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [31:0] addr = '0;
  logic [1:0] start;
  logic start_we, ready;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_ilv_sched #(.ADDR_W(32), .ACC_CYC(ACC), .PRE_CYC(PRE), .BANK_BIT(2)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wr(wr),
    .start(start), .start_we(start_we), .ready(ready));

  localparam logic [31:0] VA [NV] = '{32'h0000_0000, 32'h0000_0004, 32'h0000_0008,
    32'h0000_000C, 32'h0000_000C, 32'h0000_0010, 32'h0000_0014, 32'h0000_0014,
    32'h0000_0014, 32'h0000_001C, 32'h0000_0018, 32'h0000_0018, 32'hFFFF_FFF8,
    32'h8000_0006};
  localparam bit VW [NV] = '{0,1,0,0,1,0,0,1,0,1,0,1,0,1};
  localparam int VG [NV] = '{0,0,0,0,0,0,1,2,4,3,0,0,0,0};
  localparam int VL [NV] = '{0,0,0,0,4,0,0,2,0,1,0,4,4,0};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input bit w, input int gap,
                        input int exp_lat, input bit noise, input string tag);
    int lat, r;
    @(negedge clk);
    repeat (gap) @(negedge clk);
    req = 1; addr = a; wr = w;
    @(negedge clk);
    req = 0; addr = ~a;
    lat = 0;
    while (start == 2'b00 && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk({tag, " latency"}, lat, exp_lat);
    chk({tag, " start bank R1"}, start, 2'b01 << a[2]);
    chk({tag, " start_we R6"}, start_we, w);
    if (noise) begin req = 1; addr = a ^ 32'h4; end
    r = 0;
    @(negedge clk);
    req = 0;
    r = 1;
    while (!ready && r < 40) begin
      chk({tag, " single start R8"}, start, 0);
      @(negedge clk);
      r++;
    end
    chk({tag, " ready offset R3"}, r, ACC - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("reset start R3", start, 0);
    chk("reset ready R3", ready, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++)
      access(VA[i], VW[i], VG[i], VL[i], 0, $sformatf("vec%0d R4 R5 R9", i));

    access(32'h0000_0020, 0, 0, 0, 1, "noise R7");
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("ignored req start R7", start, 0);
      chk("ignored req ready R7", ready, 0);
    end

    access(32'h0000_0030, 1, 0, 0, 0, "pre-stall R6");
    access(32'h0000_0034, 0, 0, 0, 0, "other bank R5");
    access(32'h0000_0034, 1, 0, PRE, 0, "held R6");

    access(32'h0000_0040, 0, 0, 0, 0, "pre-reset");
    @(negedge clk);
    req = 1; addr = 32'h0000_0048; wr = 0;
    @(negedge clk);
    req = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("reset drops stall R10", start, 0);
    end
    access(32'h0000_0048, 1, 0, 0, 0, "after reset R10 R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule